// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Controller

This block holds the control and status word of a single general-purpose pin. Software writes this word through a plain write strobe and reads it back on a combinational read bus. The word sets the pad drive: an output-enable bit and an output-value bit. It also shows the input level of the pin, sampled by the block's clock. The block watches the input for a trigger condition. The condition is either an edge or a level, and the polarity is selectable.

A trigger does two separate things. It sets an interrupt status flag, which depends on an enable bit and is gated onward by an unmask bit. It can also set a wake status flag, which depends on three wake-enable bits, one for each low-power state. A sleep-state input names the current state. Both status flags are cleared by writing one to them.

Three outputs go toward a status aggregator: the gated interrupt request, the wake request, and their OR. Input filtering is assumed to happen upstream. Address decoding is also outside this block.

Top module: `gpio_pin_ctl`

## Requirements
- R1: After reset every control bit, both status flags and the sampled pin level read 0, and pad_oe, pad_out, irq_out, wake_out and pending are all 0.
- R2: A write sets pad_oe to bit 0 and pad_out to bit 1 of the written word, and the new values appear in the next cycle.
- R3: Read bit 10 is the pad_in level sampled at the previous clock edge. Writes never alter bit 10.
- R4: Bit 2 is the sense bit, where 1 means level and 0 means edge. Bits 4:3 are the polarity code. In edge mode, code 00 sets the interrupt status (bit 11) on a 0-to-1 input change only.
- R5: In edge mode, polarity code 01 sets the interrupt status on a 1-to-0 change only.
- R6: In edge mode, polarity code 10 sets the interrupt status on any change. In level mode, codes 10 and 11 never set it.
- R7: In level mode with the enable (bit 5) set, the interrupt status follows the input level one cycle later. Code 00 is active high and code 01 is active low. Writing 1 to bit 11 has no effect while the active level is present.
- R8: With bit 5 at 0, a trigger does not set the interrupt status, and a status that is already set stays set.
- R9: In edge mode, writing 1 to bit 11 clears the interrupt status, and writing 0 to bit 11 leaves it unchanged.
- R10: irq_out is the interrupt status ANDed with the unmask bit (bit 6). With bit 6 at 0, no request is forwarded.
- R11: sleep_state selects a wake-enable bit: 1 selects bit 7, 2 selects bit 8 and 3 selects bit 9. State 0 means running, and nothing wakes in that state. A trigger while the selected wake bit is set sets the wake status (bit 12) whatever bit 5 says, and leaves bit 11 alone. Writing 1 to bit 12 clears the wake status.
- R12: wake_out equals the wake status, and pending is irq_out OR wake_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | WORD_W | Data to write |
| rd_data | output | WORD_W | Current control and status word |
| pad_in | input | 1 | Filtered input level of the pin |
| sleep_state | input | SLP_W | Current power state (0 = running) |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |
| irq_out | output | 1 | Unmasked interrupt request |
| wake_out | output | 1 | Wake request |
| pending | output | 1 | OR of irq_out and wake_out |

## Verification
Each status flag is a single register, and it is visible both on the read bus and on an output pin in the cycle after the input change that sets it. A wrong polarity decode or a missed set is therefore seen one cycle after the input change. A flag that sticks or clears wrongly is seen at the first read or request after a clear write, or after a disable. A wrong mode decode makes a flag appear or vanish when the input moves. Wake and interrupt flags are checked against each other, so if either one leaks into the other, the status bit that should have stayed at zero shows it immediately.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int B_OE     = 0;
  localparam int B_OVAL   = 1;
  localparam int B_SENSE  = 2;
  localparam int B_POL    = 3;   // two bits: 4:3
  localparam int B_EN     = 5;
  localparam int B_UNMASK = 6;
  localparam int B_WAKE   = 7;   // three bits: 9:7
  localparam int B_PIN    = 10;
  localparam int B_ISTS   = 11;
  localparam int B_WSTS   = 12;
  localparam int USED_W   = 13;

  typedef enum logic [1:0] {
    POL_HIGH = 2'b00,
    POL_LOW  = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_e;

  typedef struct packed {
    logic [2:0] wake_en;
    logic       unmask;
    logic       en;
    pol_e       pol;
    logic       level;
    logic       oval;
    logic       oe;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_pin_trig.sv
module gpio_pin_trig
  import gpio_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pad_in,
  input  logic level_mode,
  input  pol_e pol,
  output logic pin_q,
  output logic hit
);
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pad_in;
  end

  assign rise = pad_in & ~pin_q;
  assign fall = ~pad_in & pin_q;

  always_comb begin
    unique case (pol)
      POL_HIGH: hit = level_mode ? pad_in  : rise;
      POL_LOW:  hit = level_mode ? ~pad_in : fall;
      POL_BOTH: hit = level_mode ? 1'b0    : (rise | fall);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_flag.sv
module gpio_pin_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic track,
  input  logic track_val,
  input  logic clr,
  output logic sts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sts <= 1'b0;
    else if (track)   sts <= track_val;
    else if (set_evt) sts <= 1'b1;
    else if (clr)     sts <= 1'b0;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr && !track) |=> sts);
  p_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts && !set_evt && !track) |=> !sts);
  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt && !track) |=> !sts);
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
  import gpio_pin_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WAKE  = 3,
  localparam int SLP_W    = $clog2(NUM_WAKE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              pad_in,
  input  logic [SLP_W-1:0]  sleep_state,
  output logic              pad_oe,
  output logic              pad_out,
  output logic              irq_out,
  output logic              wake_out,
  output logic              pending
);
  pin_cfg_t cfg;
  logic pin_q, hit, irq_sts, wake_sts;
  logic clr_irq, clr_wake, wake_sel;
  logic [NUM_WAKE-1:0] wake_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (wr_en) begin
      cfg.oe      <= wr_data[B_OE];
      cfg.oval    <= wr_data[B_OVAL];
      cfg.level   <= wr_data[B_SENSE];
      cfg.pol     <= pol_e'(wr_data[B_POL +: 2]);
      cfg.en      <= wr_data[B_EN];
      cfg.unmask  <= wr_data[B_UNMASK];
      cfg.wake_en <= wr_data[B_WAKE +: 3];
    end
  end

  assign clr_irq  = wr_en & wr_data[B_ISTS];
  assign clr_wake = wr_en & wr_data[B_WSTS];

  gpio_pin_trig u_trig (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .level_mode(cfg.level), .pol(cfg.pol),
    .pin_q(pin_q), .hit(hit)
  );

  for (genvar w = 0; w < NUM_WAKE; w++) begin : g_wake
    assign wake_match[w] = cfg.wake_en[w] && (sleep_state == SLP_W'(w + 1));
  end
  assign wake_sel = |wake_match;

  gpio_pin_flag u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_evt(cfg.en & hit & ~cfg.level),
    .track(cfg.en & cfg.level),
    .track_val(hit),
    .clr(clr_irq),
    .sts(irq_sts)
  );

  gpio_pin_flag u_wake (
    .clk(clk), .rst_n(rst_n),
    .set_evt(hit & wake_sel),
    .track(1'b0),
    .track_val(1'b0),
    .clr(clr_wake),
    .sts(wake_sts)
  );

  assign pad_oe   = cfg.oe;
  assign pad_out  = cfg.oval;
  assign irq_out  = irq_sts & cfg.unmask;
  assign wake_out = wake_sts;
  assign pending  = irq_out | wake_out;

  always_comb begin
    rd_data             = '0;
    rd_data[B_OE]       = cfg.oe;
    rd_data[B_OVAL]     = cfg.oval;
    rd_data[B_SENSE]    = cfg.level;
    rd_data[B_POL +: 2] = cfg.pol;
    rd_data[B_EN]       = cfg.en;
    rd_data[B_UNMASK]   = cfg.unmask;
    rd_data[B_WAKE +: 3] = cfg.wake_en;
    rd_data[B_PIN]      = pin_q;
    rd_data[B_ISTS]     = irq_sts;
    rd_data[B_WSTS]     = wake_sts;
  end

  p_oe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pad_oe == $past(wr_data[B_OE])) && (pad_out == $past(wr_data[B_OVAL])));
  p_run_no_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_state == '0 && !wake_sts) |=> !wake_sts);
  p_level_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.level && cfg.en && cfg.pol[1]) |=> !irq_sts);
  initial p_width_ok: assert (WORD_W >= USED_W && NUM_WAKE == 3);
endmodule

// File: tb/gpio_pin_ctl_tb.sv
module gpio_pin_ctl_tb;
  localparam int WORD_W = 16;
  localparam int SLP_W  = 2;
  localparam int NV     = 17;

  logic clk = 0, rst_n = 0, wr_en = 0, pad_in = 0;
  logic [WORD_W-1:0] wr_data = '0;
  logic [SLP_W-1:0]  sleep_state = '0;
  logic [WORD_W-1:0] rd_data;
  logic pad_oe, pad_out, irq_out, wake_out, pending;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  gpio_pin_ctl #(.WORD_W(WORD_W), .NUM_WAKE(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .sleep_state(sleep_state),
    .pad_oe(pad_oe), .pad_out(pad_out), .irq_out(irq_out),
    .wake_out(wake_out), .pending(pending)
  );

  // {cfg[7:0], p0, p1, exp_status, exp_irq_out}
  localparam logic [11:0] VEC [NV] = '{
    {8'h60, 1'b0, 1'b1, 1'b1, 1'b1},  // R4 rise
    {8'h60, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 fall ignored
    {8'h68, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 fall
    {8'h68, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 rise ignored
    {8'h70, 1'b0, 1'b1, 1'b1, 1'b1},  // R6 both, rise
    {8'h70, 1'b1, 1'b0, 1'b1, 1'b1},  // R6 both, fall
    {8'h70, 1'b1, 1'b1, 1'b0, 1'b0},  // R6 no change
    {8'h74, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 level + both code
    {8'h7C, 1'b1, 1'b0, 1'b0, 1'b0},  // R6 level + reserved code
    {8'h64, 1'b0, 1'b1, 1'b1, 1'b1},  // R7 level high active
    {8'h64, 1'b1, 1'b0, 1'b0, 1'b0},  // R7 level high inactive
    {8'h6C, 1'b1, 1'b0, 1'b1, 1'b1},  // R7 level low active
    {8'h6C, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 level low held
    {8'h40, 1'b0, 1'b1, 1'b0, 1'b0},  // R8 disabled
    {8'h20, 1'b0, 1'b1, 1'b1, 1'b0},  // R10 masked
    {8'h28, 1'b1, 1'b0, 1'b1, 1'b0},  // R10 masked fall
    {8'h30, 1'b0, 1'b1, 1'b1, 1'b0}   // R10 masked both
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [WORD_W-1:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    chk(rd_data == '0, "R1 rd_data", rd_data, 0);
    chk({pad_oe, pad_out, irq_out, wake_out, pending} == 5'b0, "R1 outputs",
        {pad_oe, pad_out, irq_out, wake_out, pending}, 0);
    rst_n = 1;
    tick(1);
    chk(rd_data == '0, "R1 after release", rd_data, 0);

    // R2 pad drive
    wr(16'h0003);
    chk(pad_oe == 1 && pad_out == 1, "R2 oe/out set", {pad_oe, pad_out}, 3);
    wr(16'h0001);
    chk(pad_oe == 1 && pad_out == 0, "R2 out low", {pad_oe, pad_out}, 2);

    // R3 pin level readback
    pad_in = 1; tick(1);
    chk(rd_data[10] == 1, "R3 pin high", rd_data[10], 1);
    wr(16'h0000);
    chk(rd_data[10] == 1, "R3 write ignored", rd_data[10], 1);
    pad_in = 0; tick(1);
    chk(rd_data[10] == 0, "R3 pin low", rd_data[10], 0);

    // table walk (R4..R8, R10, R12)
    for (int i = 0; i < NV; i++) begin
      logic [7:0] c;
      logic p0, p1, es, ei;
      {c, p0, p1, es, ei} = VEC[i];
      pad_in = p0;
      wr({3'b0, 1'b1, 4'b0, c} | 16'h1800);
      tick(2);
      wr({8'h18, c});
      tick(1);
      pad_in = p1;
      tick(1);
      chk(rd_data[11] == es, $sformatf("R4-vec%0d status (R5 R6 R7 R8)", i), rd_data[11], es);
      chk(irq_out == ei, $sformatf("R10 vec%0d irq_out", i), irq_out, ei);
      chk(pending == ei, $sformatf("R12 vec%0d pending", i), pending, ei);
    end

    // R7 clear has no effect while level active
    pad_in = 0; wr(16'h0864); tick(1);
    pad_in = 1; tick(1);
    wr(16'h0864);
    chk(rd_data[11] == 1, "R7 clear ignored while active", rd_data[11], 1);
    pad_in = 0; tick(1);
    chk(rd_data[11] == 0, "R7 follows level", rd_data[11], 0);

    // R9 write-one-to-clear in edge mode
    wr(16'h0860); tick(1);
    pad_in = 1; tick(1);
    chk(rd_data[11] == 1, "R9 set", rd_data[11], 1);
    wr(16'h0060);
    chk(rd_data[11] == 1, "R9 write 0 keeps", rd_data[11], 1);
    wr(16'h0860);
    chk(rd_data[11] == 0, "R9 write 1 clears", rd_data[11], 0);

    // R8 disable keeps existing status
    pad_in = 0; tick(1);
    pad_in = 1; tick(1);
    wr(16'h0040);
    chk(rd_data[11] == 1, "R8 kept after disable", rd_data[11], 1);
    wr(16'h0840);
    pad_in = 0; tick(1);
    pad_in = 1; tick(1);
    chk(rd_data[11] == 0, "R8 no new latch", rd_data[11], 0);

    // R11 wake
    pad_in = 0; wr(16'h1900); tick(1);
    sleep_state = 2;
    pad_in = 1; tick(1);
    chk(rd_data[12] == 1, "R11 wake set", rd_data[12], 1);
    chk(rd_data[11] == 0, "R11 irq untouched", rd_data[11], 0);
    chk(wake_out == 1 && pending == 1 && irq_out == 0, "R12 wake pending",
        {wake_out, pending, irq_out}, 6);
    wr(16'h1100);
    chk(rd_data[12] == 0 && wake_out == 0, "R11 wake clear", rd_data[12], 0);
    sleep_state = 1;
    pad_in = 0; tick(1); pad_in = 1; tick(1);
    chk(rd_data[12] == 0, "R11 other state no wake", rd_data[12], 0);
    sleep_state = 0;
    pad_in = 0; tick(1); pad_in = 1; tick(1);
    chk(rd_data[12] == 0, "R11 running no wake", rd_data[12], 0);
    sleep_state = 3; wr(16'h0200);
    pad_in = 0; tick(1); pad_in = 1; tick(1);
    chk(rd_data[12] == 1, "R11 off-state wake", rd_data[12], 1);

    finish_run();
  end
endmodule